// File: doc/BRIEF.md
# I2C Slave Address Match Unit

This block decides whether an address byte seen on an I2C bus is meant for this slave. A shifter outside the block hands over each completed address byte on a valid/ready input. The upper seven bits of the byte are compared with a programmable own address. When a general-call enable is set, the byte is also compared with the general call address. The block returns one registered result per accepted byte. The result gives the match decision, a general-call flag, the R/W bit and the level to drive in the acknowledge slot.

The decision is combinational logic followed by a single register stage. Nothing in it depends on a processor, so the block can run from a bus-side clock while the processor is asleep. A `wake_req` pulse announces every match.

The input is accepted on a cycle where `in_valid` and `in_ready` are both high. The own address, the general-call enable and the acknowledge enable are sampled on that same cycle. A result waits in the output register until `res_valid` and `res_ready` are both high, and it does not change while it waits. `in_ready` is high whenever the output register is empty or is being emptied in the current cycle. While a result is held, new bytes therefore wait at the input.

Top module: `i2c_addr_match`

## Requirements
- R1: When `own_addr` is non-zero and `in_byte[7:1]` equals `own_addr`, the result has `res_match`=1 and `res_gcall`=0. This holds for either R/W value.
- R2: `res_rnw` equals `in_byte[0]` of the accepted byte, for every result.
- R3: When `gc_en`=1 and `in_byte` is 8'h00, the result has `res_match`=1 and `res_gcall`=1.
- R4: When `gc_en`=0, an `in_byte` of 8'h00 gives `res_match`=0 and `res_gcall`=0, unless R1 matches it.
- R5: An `in_byte` of 8'h01 (all-zero address with R/W=1) never gives `res_gcall`=1. It gives `res_match`=0 unless R1 matches it.
- R6: An `own_addr` of 7'h00 never matches through the own-address path. With that setting, a byte of 8'h00 matches only under R3.
- R7: `res_ack_n` is 0 (acknowledge) exactly when `res_match`=1 and `ack_en` was 1 at acceptance. Otherwise it is 1.
- R8: A result appears with `res_valid`=1 on the cycle after acceptance. While `res_ready`=0 it stays valid and unchanged. `in_ready` = !`res_valid` || `res_ready`.
- R9: `wake_req` pulses for exactly one cycle, on the cycle a matching result first appears. Non-matching results give no pulse.
- R10: After reset, `res_valid`=0, `res_ack_n`=1, `wake_req`=0 and `in_ready`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | active-low asynchronous reset |
| in_valid | input | 1 | an address byte is offered |
| in_ready | output | 1 | the block can accept a byte this cycle |
| in_byte | input | 8 | address byte; bits 7:1 are the address, bit 0 is R/W |
| own_addr | input | 7 | programmable own slave address |
| gc_en | input | 1 | enables general-call recognition |
| ack_en | input | 1 | allows a matched address to be acknowledged |
| res_valid | output | 1 | a result is held |
| res_ready | input | 1 | the consumer takes the result |
| res_match | output | 1 | the address is for this slave |
| res_gcall | output | 1 | the match was a general call |
| res_rnw | output | 1 | R/W bit of the byte |
| res_ack_n | output | 1 | acknowledge-slot level, 0 means acknowledge |
| wake_req | output | 1 | one-cycle wake request on a match |

## Verification
The bench sends the all-zero address with R/W set while general call is enabled. A design that ignores the R/W bit in the general-call compare would wrongly claim that byte. The bench also programs an own address of zero with general call disabled. A design that lets the own-address path see the reserved address would match and then acknowledge. Acknowledge enable is toggled on both matching and non-matching bytes, so that a design that acknowledges without a match is exposed. Long stalls on `res_ready` show whether a design lets a held result change, drops a result or sends extra wake pulses.

// File: rtl/i2c_am_pkg.sv
package i2c_am_pkg;
  localparam int unsigned ADDR_W = 7;
  localparam int unsigned BYTE_W = ADDR_W + 1;

  typedef struct packed {
    logic match;
    logic gcall;
    logic rnw;
    logic ack_n;
  } am_result_t;
endpackage

// File: rtl/am_compare.sv
module am_compare
  import i2c_am_pkg::*;
#(
  parameter int unsigned AW = ADDR_W
) (
  input  logic [AW:0]   addr_byte,
  input  logic [AW-1:0] own,
  input  logic          gc_enable,
  output logic          own_hit,
  output logic          gc_hit
);
  localparam logic [AW-1:0] ZERO_ADDR = '0;

  logic [AW-1:0] field;
  assign field = addr_byte[AW:1];

  // reserved all-zero address is never an own-address match
  assign own_hit = (field == own) && (own != ZERO_ADDR);
  // general call only as a write
  assign gc_hit  = gc_enable && (field == ZERO_ADDR) && !addr_byte[0];
endmodule

// File: rtl/am_ack_decide.sv
module am_ack_decide
  import i2c_am_pkg::*;
(
  input  logic       own_hit,
  input  logic       gc_hit,
  input  logic       rnw,
  input  logic       ack_enable,
  output am_result_t res
);
  always_comb begin
    res.match = own_hit | gc_hit;
    res.gcall = gc_hit & ~own_hit;
    res.rnw   = rnw;
    res.ack_n = ~(res.match & ack_enable);
  end
endmodule

// File: rtl/am_out_stage.sv
module am_out_stage
  import i2c_am_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       load,
  input  am_result_t next_res,
  input  logic       take,
  output logic       valid,
  output am_result_t held,
  output logic       wake
);
  localparam am_result_t RST_RES = '{match: 1'b0, gcall: 1'b0, rnw: 1'b0, ack_n: 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid <= 1'b0;
      held  <= RST_RES;
      wake  <= 1'b0;
    end else begin
      wake <= load & next_res.match;
      if (load) begin
        valid <= 1'b1;
        held  <= next_res;
      end else if (take) begin
        valid <= 1'b0;
      end
    end
  end

  assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && !take) |=> (valid && $stable(held)));
  assert_ack_needs_match_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && !held.ack_n) |-> held.match);
  assert_gcall_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && held.gcall) |-> (held.match && !held.rnw));
  assert_wake_match_R9: assert property (@(posedge clk) disable iff (!rst_n)
    wake |-> (valid && held.match));
  assert_wake_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
    wake |=> (!wake || $past(load)));
endmodule

// File: rtl/i2c_addr_match.sv
module i2c_addr_match
  import i2c_am_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [BYTE_W-1:0] in_byte,
  input  logic [ADDR_W-1:0] own_addr,
  input  logic              gc_en,
  input  logic              ack_en,
  output logic              res_valid,
  input  logic              res_ready,
  output logic              res_match,
  output logic              res_gcall,
  output logic              res_rnw,
  output logic              res_ack_n,
  output logic              wake_req
);
  logic       own_hit, gc_hit, in_fire;
  am_result_t comb_res, held_res;

  assign in_ready = !res_valid || res_ready;
  assign in_fire  = in_valid && in_ready;

  am_compare #(.AW(ADDR_W)) u_cmp (
    .addr_byte (in_byte),
    .own       (own_addr),
    .gc_enable (gc_en),
    .own_hit   (own_hit),
    .gc_hit    (gc_hit)
  );

  am_ack_decide u_ack (
    .own_hit    (own_hit),
    .gc_hit     (gc_hit),
    .rnw        (in_byte[0]),
    .ack_enable (ack_en),
    .res        (comb_res)
  );

  am_out_stage u_out (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (in_fire),
    .next_res (comb_res),
    .take     (res_ready),
    .valid    (res_valid),
    .held     (held_res),
    .wake     (wake_req)
  );

  assign res_match = held_res.match;
  assign res_gcall = held_res.gcall;
  assign res_rnw   = held_res.rnw;
  assign res_ack_n = held_res.ack_n;

  assert_accept_R8: assert property (@(posedge clk) disable iff (!rst_n)
    in_fire |=> res_valid);
  assert_rnw_R2: assert property (@(posedge clk) disable iff (!rst_n)
    in_fire |=> (res_rnw == $past(in_byte[0])));
endmodule

// File: tb/test_i2c_addr_match.sv
module test_i2c_addr_match;
  logic clk = 1'b0, rst_n = 1'b0;
  logic in_valid = 1'b0, in_ready, gc_en = 1'b0, ack_en = 1'b0, res_ready = 1'b0;
  logic [7:0] in_byte = '0;
  logic [6:0] own_addr = '0;
  logic res_valid, res_match, res_gcall, res_rnw, res_ack_n, wake_req;

  int checks = 0, errors = 0, n_match_exp = 0, n_wake = 0, cyc = 0;
  int stall_mode = 0;
  bit done = 0;
  logic [3:0] q[$];   // {match, gcall, rnw, ack_n}

  always #2.5 clk = ~clk;

  i2c_addr_match i_i2c_addr_match (.*);

  task automatic chk(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0b expected=%0b", tag, act, exp);
    end
  endtask

  task automatic send(input logic [7:0] b, input logic [6:0] own, input logic g, input logic a);
    logic own_hit, gc_hit, m;
    own_hit = (b[7:1] == own) && (own != 7'd0);
    gc_hit  = g && (b == 8'h00);
    m = own_hit | gc_hit;
    @(negedge clk);
    in_byte = b; own_addr = own; gc_en = g; ack_en = a; in_valid = 1'b1;
    #1;
    while (!in_ready) begin @(negedge clk); #1; end
    q.push_back({m, gc_hit & ~own_hit, b[0], ~(m & a)});
    if (m) n_match_exp++;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  // back-pressure driver
  always @(negedge clk) begin
    cyc++;
    case (stall_mode)
      0: res_ready <= 1'b1;
      1: res_ready <= (cyc % 3) != 0;
      default: res_ready <= (cyc % 9) == 0;
    endcase
  end

  // monitor / scoreboard
  always @(negedge clk) begin
    #2;
    if (rst_n) begin
      if (wake_req) begin
        n_wake++;
        chk("R9 wake implies match", res_valid && res_match, 1'b1);
      end
      if (res_valid && res_ready) begin
        if (q.size() == 0) chk("R8 unexpected result", 1'b1, 1'b0);
        else begin
          logic [3:0] e;
          e = q.pop_front();
          chk("R1/R3/R4/R5/R6 match", res_match, e[3]);
          chk("R3 gcall", res_gcall, e[2]);
          chk("R2 rnw", res_rnw, e[1]);
          chk("R7 ack_n", res_ack_n, e[0]);
        end
      end
    end
  end

  initial begin
    #2000000;
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    chk("R10 res_valid", res_valid, 1'b0);
    chk("R10 ack_n", res_ack_n, 1'b1);
    chk("R10 wake", wake_req, 1'b0);
    chk("R10 in_ready", in_ready, 1'b1);
    rst_n = 1'b1;
    // R1 own-address match, both directions, with and without ack
    send({7'h2A, 1'b0}, 7'h2A, 1'b0, 1'b1);
    send({7'h2A, 1'b1}, 7'h2A, 1'b0, 1'b0);
    send({7'h2B, 1'b0}, 7'h2A, 1'b1, 1'b1);
    // R3 / R4 / R5 general call
    send(8'h00, 7'h2A, 1'b1, 1'b1);
    send(8'h00, 7'h2A, 1'b0, 1'b1);
    send(8'h01, 7'h2A, 1'b1, 1'b1);
    // R6 zero own address
    send(8'h00, 7'h00, 1'b0, 1'b1);
    send(8'h01, 7'h00, 1'b1, 1'b1);
    send(8'h00, 7'h00, 1'b1, 1'b0);
    send(8'hFF, 7'h7F, 1'b0, 1'b1);
    // R8 back-pressure patterns
    stall_mode = 1;
    for (int i = 0; i < 24; i++)
      send(8'(i * 37), 7'(i * 5), 1'(i % 2), 1'(i % 3 != 0));
    stall_mode = 2;
    for (int i = 0; i < 16; i++)
      send(8'(i * 11), 7'(i * 11 >> 1), 1'(i % 2), 1'b1);
    stall_mode = 0;
    while (q.size() != 0) @(negedge clk);
    repeat (4) @(negedge clk);
    chk("R9 wake count", n_wake == n_match_exp, 1'b1);
    #1;
    chk("R8 in_ready idle", in_ready, 1'b1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule